// File: doc/BRIEF.md
# Supply Switchover and Reset Sequencer

This block decides, on a slow always-on clock, which of two supply sources feeds the digital core of a battery monitor, and when that core may leave reset. The cell-stack voltage reaches it through two comparator flags. One flag says the stack is above the upper switchover level. The other says it is below the lower level. The battery path is taken on the first flag and dropped on the second, so a stack voltage inside the band keeps the current source. A switch from one path to the other always passes through one slow-clock cycle with both paths off.

The regulator is also seen through two flags: one below its trip level, and one above trip plus hysteresis. A dip holds the core in reset at once. Release needs an unbroken run of samples above the upper level, and the length of that run is a parameter. When reset ends, the block raises a trim-load request and holds it until the trim logic acknowledges. Only then does it report normal run. All pins are plain control and status levels, so there is no streaming interface and no back-pressure.

Top module: `supply_seq_top`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, sel_pack=1, sel_bat=0, core_rst=1, trim_req=0 and run_ok=0.
- R2: With the pack path selected, an edge that samples stk_above_hi=1 drops sel_pack at that edge, and sel_bat rises at the next edge.
- R3: With the battery path selected, an edge that samples stk_below_lo=1 drops sel_bat at that edge, and sel_pack rises at the next edge.
- R4: sel_bat and sel_pack are never both 1.
- R5: While both stack flags are 0, the selected path does not change. stk_below_lo has no effect while the pack path is selected, and stk_above_hi has no effect while the battery path is selected.
- R6: An edge that samples reg_below_trip=1 sets core_rst to 1 at that edge and restarts the hold count from zero.
- R7: core_rst falls at the edge that completes HOLD_CYCLES consecutive samples with reg_above_hyst=1 and reg_below_trip=0. A sample with reg_above_hyst=0 restarts the count.
- R8: trim_req rises at the edge after core_rst falls, and stays 1 until an edge samples trim_done=1.
- R9: The edge that samples trim_done=1 while trim_req=1 clears trim_req and sets run_ok. trim_done has no effect while core_rst=1 or run_ok=1.
- R10: Re-entry into reset clears trim_req and run_ok at the same edge where core_rst rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency always-on clock |
| rst_n | input | 1 | Asynchronous power-on reset of the sequencer, active low |
| stk_above_hi | input | 1 | Stack above switchover level plus hysteresis |
| stk_below_lo | input | 1 | Stack below lower switchover level |
| reg_below_trip | input | 1 | Regulator output below its trip level |
| reg_above_hyst | input | 1 | Regulator output above trip level plus hysteresis |
| trim_done | input | 1 | Acknowledge that trim values have been written |
| sel_bat | output | 1 | Select battery supply path |
| sel_pack | output | 1 | Select pack/charger supply path |
| core_rst | output | 1 | Core reset, active high |
| trim_req | output | 1 | Trim-load request, held until acknowledged |
| run_ok | output | 1 | Normal operation reached |

## Verification
The bench targets the hold-count boundary. It checks that core_rst is still high after HOLD_CYCLES-1 good samples and low after the last one. An off-by-one counter would release one cycle early or late. The bench also inserts in-band regulator samples and dips in the middle of a hold. A counter that only pauses instead of restarting would release too soon. On the supply side, the bench crosses the thresholds in both directions and also drives the flag that should be ignored. A missing dead cycle would show both paths on, or a path picked up at the wrong edge. The bench also sends an acknowledge while the core is still in reset, and drops into reset again after run. A handshake that accepted the early acknowledge, or that cleared its outputs one cycle late, would differ from the reference model.

// File: rtl/supseq_pkg.sv
package supseq_pkg;
  typedef enum logic [1:0] {
    SRC_PACK    = 2'd0,
    SRC_TO_BAT  = 2'd1,
    SRC_BAT     = 2'd2,
    SRC_TO_PACK = 2'd3
  } src_state_e;

  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,
    TR_REQ  = 2'd1,
    TR_RUN  = 2'd2
  } trim_state_e;
endpackage

// File: rtl/supply_select.sv
module supply_select
  import supseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stk_above_hi,
  input  logic stk_below_lo,
  output logic sel_bat,
  output logic sel_pack
);
  src_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRC_PACK:    if (stk_above_hi) state_d = SRC_TO_BAT;
      SRC_TO_BAT:  state_d = SRC_BAT;
      SRC_BAT:     if (stk_below_lo) state_d = SRC_TO_PACK;
      SRC_TO_PACK: state_d = SRC_PACK;
      default:     state_d = SRC_PACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SRC_PACK;
    else        state_q <= state_d;
  end

  assign sel_bat  = (state_q == SRC_BAT);
  assign sel_pack = (state_q == SRC_PACK);

  // R2: the battery path only follows a cycle with the pack path off
  a_r2_gap_before_bat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_bat) |-> !$past(sel_pack));
  // R3: the pack path only follows a cycle with the battery path off
  a_r3_gap_before_pack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_pack) |-> !$past(sel_bat));
  // R5: the battery path is kept unless the low flag is seen
  a_r5_bat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_bat && !stk_below_lo) |=> sel_bat);
  // R5: the pack path is kept unless the high flag is seen
  a_r5_pack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pack && !stk_above_hi) |=> sel_pack);
endmodule

// File: rtl/reset_timer.sv
module reset_timer #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_below_trip,
  input  logic reg_above_hyst,
  output logic hold_rst
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (reg_below_trip) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (rst_q) begin
      if (!reg_above_hyst) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_rst = rst_q;

  // R6: a regulator dip always lands in reset
  a_r6_dip_enters_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reg_below_trip |=> hold_rst);
  // R7: release is only on a good sample
  a_r7_release_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_rst) |-> $past(reg_above_hyst && !reg_below_trip));
  // R7: the count never passes the hold length
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/trim_handshake.sv
module trim_handshake
  import supseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_rst,
  input  logic trim_done,
  output logic trim_req,
  output logic run_ok
);
  trim_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (hold_rst) begin
      st_d = TR_IDLE;
    end else begin
      unique case (st_q)
        TR_IDLE: st_d = TR_REQ;
        TR_REQ:  if (trim_done) st_d = TR_RUN;
        TR_RUN:  st_d = TR_RUN;
        default: st_d = TR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TR_IDLE;
    else        st_q <= st_d;
  end

  assign trim_req = (st_q == TR_REQ) && !hold_rst;
  assign run_ok   = (st_q == TR_RUN) && !hold_rst;

  // R8: the request holds until it is acknowledged or reset returns
  a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_req && !trim_done) |=> (trim_req || hold_rst));
  // R9: run only follows an acknowledged request
  a_r9_run_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_ok) |-> $past(trim_req && trim_done));
  // R10: in reset neither the request nor run is visible
  a_r10_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |-> !(trim_req || run_ok));
endmodule

// File: rtl/supply_seq_top.sv
module supply_seq_top #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stk_above_hi,
  input  logic stk_below_lo,
  input  logic reg_below_trip,
  input  logic reg_above_hyst,
  input  logic trim_done,
  output logic sel_bat,
  output logic sel_pack,
  output logic core_rst,
  output logic trim_req,
  output logic run_ok
);
  logic hold_rst;

  supply_select u_select (
    .clk          (clk),
    .rst_n        (rst_n),
    .stk_above_hi (stk_above_hi),
    .stk_below_lo (stk_below_lo),
    .sel_bat      (sel_bat),
    .sel_pack     (sel_pack)
  );

  reset_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_below_trip (reg_below_trip),
    .reg_above_hyst (reg_above_hyst),
    .hold_rst       (hold_rst)
  );

  trim_handshake u_trim (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_rst  (hold_rst),
    .trim_done (trim_done),
    .trim_req  (trim_req),
    .run_ok    (run_ok)
  );

  assign core_rst = hold_rst;

  // R4: the two supply paths are never on together
  a_r4_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_bat && sel_pack));
  // R8: leaving reset raises the trim request on the next edge
  a_r8_req_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |=> trim_req);
endmodule

// File: tb/supply_seq_top_test.sv
module supply_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stk_above_hi = 1'b0, stk_below_lo = 1'b0;
  logic reg_below_trip = 1'b0, reg_above_hyst = 1'b0, trim_done = 1'b0;
  logic sel_bat, sel_pack, core_rst, trim_req, run_ok;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model state
  int m_src;   // 0 pack, 1 gap to bat, 2 bat, 3 gap to pack
  bit m_rst;
  int m_run;   // consecutive good regulator samples
  int m_tr;    // 0 idle, 1 request, 2 run

  supply_seq_top #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n),
    .stk_above_hi(stk_above_hi), .stk_below_lo(stk_below_lo),
    .reg_below_trip(reg_below_trip), .reg_above_hyst(reg_above_hyst),
    .trim_done(trim_done),
    .sel_bat(sel_bat), .sel_pack(sel_pack), .core_rst(core_rst),
    .trim_req(trim_req), .run_ok(run_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int next_src(int s, bit hi, bit lo);
    case (s)
      0: return hi ? 1 : 0;
      1: return 2;
      2: return lo ? 3 : 2;
      default: return 0;
    endcase
  endfunction

  function automatic int next_tr(int t, bit in_rst, bit done);
    if (in_rst) return 0;
    if (t == 0) return 1;
    if (t == 1) return done ? 2 : 1;
    return 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_rst = 1'b1; m_run = 0; m_tr = 0;
    end else begin
      int ns, nr, nt;
      bit nrst;
      ns = next_src(m_src, stk_above_hi, stk_below_lo);
      nt = next_tr(m_tr, m_rst, trim_done);
      nrst = m_rst; nr = m_run;
      if (reg_below_trip) begin nrst = 1'b1; nr = 0; end
      else if (m_rst) begin
        if (reg_above_hyst) nr = m_run + 1; else nr = 0;
        if (nr >= HOLD) begin nrst = 1'b0; nr = 0; end
      end
      m_src = ns; m_rst = nrst; m_run = nr; m_tr = nt;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 sel_bat", sel_bat, m_src == 2);
    chk("R2 R3 sel_pack", sel_pack, m_src == 0);
    chk("R4 mutex", sel_bat & sel_pack, 1'b0);
    chk("R6 R7 core_rst", core_rst, m_rst);
    chk("R8 trim_req", trim_req, (m_tr == 1) && !m_rst);
    chk("R9 run_ok", run_ok, (m_tr == 2) && !m_rst);
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare_all();
  endtask

  task automatic set_inputs(bit hi, bit lo, bit dip, bit good, bit done);
    stk_above_hi = hi; stk_below_lo = lo;
    reg_below_trip = dip; reg_above_hyst = good; trim_done = done;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_inputs(0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1 sel_pack in reset", sel_pack, 1'b1);
    chk("R1 sel_bat in reset", sel_bat, 1'b0);
    chk("R1 core_rst in reset", core_rst, 1'b1);
    chk("R1 trim_req in reset", trim_req, 1'b0);
    chk("R1 run_ok in reset", run_ok, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1: first cycle after reset with idle inputs
    step();
    chk("R1 core_rst after reset", core_rst, 1'b1);
    chk("R1 sel_pack after reset", sel_pack, 1'b1);

    // R9: acknowledge during reset is ignored; R7 hold boundary
    set_inputs(0, 0, 0, 1, 1);
    for (int i = 1; i <= HOLD; i++) begin
      step();
      if (i == HOLD - 1) chk("R7 still held one short", core_rst, 1'b1);
      if (i == HOLD) chk("R7 released at hold end", core_rst, 1'b0);
    end
    chk("R9 early ack ignored", run_ok, 1'b0);
    trim_done = 1'b0;
    step();
    chk("R8 request after release", trim_req, 1'b1);
    repeat (3) step();
    chk("R8 request held", trim_req, 1'b1);
    trim_done = 1'b1;
    step();
    chk("R9 run after ack", run_ok, 1'b1);
    chk("R9 request cleared", trim_req, 1'b0);

    // R10: dip while running
    set_inputs(0, 0, 1, 0, 0);
    step();
    chk("R10 core_rst on dip", core_rst, 1'b1);
    chk("R10 run_ok cleared", run_ok, 1'b0);

    // R6 R7: partial hold interrupted by band sample and dip
    set_inputs(0, 0, 0, 1, 0);
    repeat (HOLD - 2) step();
    reg_above_hyst = 1'b0;
    step();
    reg_above_hyst = 1'b1;
    repeat (HOLD - 1) step();
    chk("R7 band sample restarts count", core_rst, 1'b1);
    reg_below_trip = 1'b1;
    step();
    reg_below_trip = 1'b0;
    repeat (HOLD - 1) step();
    chk("R6 dip restarts count", core_rst, 1'b1);
    step();
    chk("R6 R7 release after fresh hold", core_rst, 1'b0);

    // R5: band and ignored flag keep pack path
    set_inputs(0, 1, 0, 1, 0);
    repeat (4) step();
    chk("R5 low flag ignored on pack", sel_pack, 1'b1);
    // R2: switch to battery with a dead cycle
    stk_below_lo = 1'b0; stk_above_hi = 1'b1;
    step();
    chk("R2 pack dropped", sel_pack, 1'b0);
    chk("R2 gap cycle", sel_bat, 1'b0);
    stk_above_hi = 1'b0;
    step();
    chk("R2 battery selected", sel_bat, 1'b1);
    stk_above_hi = 1'b1;
    repeat (3) step();
    chk("R5 high flag ignored on battery", sel_bat, 1'b1);
    stk_above_hi = 1'b0;
    repeat (3) step();
    chk("R5 band keeps battery", sel_bat, 1'b1);
    // R3: back to pack
    stk_below_lo = 1'b1;
    step();
    chk("R3 battery dropped", sel_bat, 1'b0);
    chk("R3 gap cycle", sel_pack, 1'b0);
    step();
    chk("R3 pack selected", sel_pack, 1'b1);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int rr, rs;
      rr = $urandom_range(0, 99);
      rs = $urandom_range(0, 99);
      reg_below_trip = (rr < 2);
      reg_above_hyst = (rr >= 6);
      stk_above_hi = (rs < 12);
      stk_below_lo = (rs >= 12 && rs < 24);
      trim_done = ($urandom_range(0, 3) == 0);
      step();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule